// File: doc/BRIEF.md
# Snapshot-Read 64-bit Up-Counter

This block holds a free-running up-counter, 64 bits wide by default. It advances by one on every clock cycle where a tick-enable input is high. Software cannot read 64 bits in one access, so it reads the count through a snapshot. It writes a request bit in a control register. The block then copies the whole count into a shadow register and clears the request bit once the copy is in place. Software polls that bit and then reads the two 32-bit halves of the shadow register.

The request reaches the counter after a fixed delay, LATCH_DELAY cycles, which stands in for synchronisation into the counter's domain. The counter keeps running during a snapshot and after it. The shadow register changes only when a snapshot completes, so the two halves always belong to the same captured value, whichever half is read first. The register port is plain control and status: a single-cycle write strobe and a combinational read, with no handshake and no back-pressure.

Top module: `latched_counter64`

## Requirements
- R1: After reset the counter and the shadow register are zero, and the control register reads 0.
- R2: The counter adds one, modulo 2^CNT_W, at each rising edge where `tick_en` is high. It holds its value at edges where `tick_en` is low.
- R3: Reads are combinational from `addr`. Address 0xA0 is control: bit 1 is the pending flag and every other bit reads 0. Address 0xA4 returns shadow bits 31:0, and address 0xA8 returns shadow bits 63:32 (zero-extended). Any other address reads 0.
- R4: A write to 0xA0 with bit 1 set while no snapshot is pending starts a snapshot. Bit 1 of the control register reads 1 from the next cycle on.
- R5: A snapshot completes at the LATCH_DELAY-th rising edge after the request edge. At that edge the pending flag clears, and the shadow register takes the count as it stood just before that edge. An increment at the same edge is not included.
- R6: The shadow register changes only at the completion of a snapshot. The counter runs through and after the snapshot without a gap.
- R7: A request written while a snapshot is pending is ignored. This includes a request at the completion edge itself. It neither restarts nor extends the delay.
- R8: A write to 0xA0 with bit 1 clear, and any write to another address, has no effect on the counter, the shadow register or the pending flag.
- R9: Reading any register has no side effect, so the low and high words of a completed snapshot may be read in either order, any number of times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable for the current cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` |

## Verification
A snapshot capture and a counter increment can fall on the same rising edge, and a new request can arrive at the edge where the pending snapshot completes. The bench holds `tick_en` high and drives requests so that their completion edges line up with increments. It also drives some requests exactly at a completion edge. A behavioural model predicts the pre-increment value in the shadow register and predicts that the coincident request is dropped. The model is compared against every register after every clock.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  localparam int unsigned REG_AW    = 8;
  localparam int unsigned WORD_W    = 32;
  localparam logic [REG_AW-1:0] OFS_CTRL = 8'hA0;
  localparam logic [REG_AW-1:0] OFS_LOW  = 8'hA4;
  localparam logic [REG_AW-1:0] OFS_HIGH = 8'hA8;
  localparam int unsigned SNAP_BIT  = 1;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOW  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
    case (a)
      OFS_CTRL: return SEL_CTRL;
      OFS_LOW:  return SEL_LOW;
      OFS_HIGH: return SEL_HIGH;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/snapcnt_counter.sv
module snapcnt_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (tick_en) count_q <= count_q + CNT_W'(1);
  end

  assign count = count_q;
endmodule

// File: rtl/snapcnt_latch.sv
module snapcnt_latch #(
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned LATCH_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] count,
  output logic             pending,
  output logic [CNT_W-1:0] shadow
);
  localparam int unsigned WAIT_W = (LATCH_DELAY > 1) ? $clog2(LATCH_DELAY) : 1;
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(LATCH_DELAY - 1);

  logic              pend_q;
  logic [WAIT_W-1:0] wait_q;
  logic [CNT_W-1:0]  shadow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      wait_q   <= '0;
      shadow_q <= '0;
    end else if (pend_q) begin
      if (wait_q == '0) begin
        shadow_q <= count;
        pend_q   <= 1'b0;
      end else begin
        wait_q <= wait_q - WAIT_W'(1);
      end
    end else if (req) begin
      pend_q <= 1'b1;
      wait_q <= WAIT_INIT;
    end
  end

  assign pending = pend_q;
  assign shadow  = shadow_q;
endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pending,
  input  logic [CNT_W-1:0]  shadow,
  output logic              snap_req,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned FULL_W = 2 * WORD_W;

  logic [FULL_W-1:0] shadow_ext;
  reg_sel_e          sel;

  generate
    if (CNT_W < FULL_W) begin : g_pad
      assign shadow_ext = {{(FULL_W - CNT_W){1'b0}}, shadow};
    end else begin : g_full
      assign shadow_ext = shadow[FULL_W-1:0];
    end
  endgenerate

  assign sel      = decode_addr(addr);
  assign snap_req = wr_en && (sel == SEL_CTRL) && wdata[SNAP_BIT];

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL: rdata[SNAP_BIT] = pending;
      SEL_LOW:  rdata = shadow_ext[WORD_W-1:0];
      SEL_HIGH: rdata = shadow_ext[FULL_W-1:WORD_W];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/latched_counter64.sv
module latched_counter64
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned LATCH_DELAY = 2,
  parameter int unsigned ADDR_W      = REG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] shadow;
  logic             pending;
  logic             snap_req;

  snapcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count)
  );

  snapcnt_latch #(.CNT_W(CNT_W), .LATCH_DELAY(LATCH_DELAY)) u_snap (
    .clk(clk), .rst_n(rst_n), .req(snap_req), .count(count),
    .pending(pending), .shadow(shadow)
  );

  snapcnt_regs #(.CNT_W(CNT_W)) u_regs (
    .wr_en(wr_en), .addr(REG_AW'(addr)), .wdata(wdata),
    .pending(pending), .shadow(shadow),
    .snap_req(snap_req), .rdata(rdata)
  );
endmodule

// File: rtl/latched_counter64_chk.sv
module latched_counter64_chk #(
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned LATCH_DELAY = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             snap_req,
  input logic             pending,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] shadow
);
  logic [31:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !pending) age_q <= '0;
    else                    age_q <= age_q + 32'd1;
  end

  // R2
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> count == $past(count) + CNT_W'(1));
  // R2
  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));
  // R4
  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_req && !pending) |=> pending);
  // R5
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> shadow == $past(count));
  // R7 (delay not restarted by extra requests)
  a_r7_fixed_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> age_q == 32'(LATCH_DELAY));
  // R6
  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pending) |-> $stable(shadow));
endmodule

bind latched_counter64 latched_counter64_chk #(
  .CNT_W(CNT_W), .LATCH_DELAY(LATCH_DELAY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .snap_req(snap_req),
  .pending(pending), .count(count), .shadow(shadow)
);

// File: tb/latched_counter64_test.sv
`timescale 1ns/100ps
module latched_counter64_test;
  localparam int unsigned D = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  longint unsigned m_cnt = 0, m_shadow = 0;
  bit m_pend = 1'b0;
  int m_age  = 0;

  always #2.5 clk = ~clk;

  latched_counter64 #(.LATCH_DELAY(D)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic probe(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #0.5;
    n_checks++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h actual=%h expected=%h at %0t", tag, a, rdata, exp, $time);
    end
  endtask

  task automatic probe_all(input string ctag, input string wtag);
    probe(8'hA0, {30'd0, m_pend, 1'b0}, ctag);
    probe(8'hA8, m_shadow[63:32], wtag);
    probe(8'hA4, m_shadow[31:0], wtag);
    probe(8'h00, 32'd0, "R3 unmapped address");
  endtask

  // one clock: drive, edge, model update, compare everything
  task automatic step(input bit t, input bit w, input logic [7:0] a, input logic [31:0] d);
    bit req;
    tick_en = t; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    req = w && (a == 8'hA0) && d[1];
    if (m_pend) begin
      if (m_age + 1 == D) begin
        m_shadow = m_cnt;
        m_pend   = 1'b0;
      end else m_age++;
    end else if (req) begin
      m_pend = 1'b1;
      m_age  = 0;
    end
    if (t) m_cnt++;
    #1;
    wr_en = 1'b0;
    probe_all("R4 R5 R7 R8 pending bit", "R2 R5 R6 R9 snapshot word");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    probe_all("R1 reset control", "R1 reset shadow");
    rst_n = 1'b1;

    // counter runs, shadow stays zero (R6)
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 8'h00, 32'd0);
    // basic snapshot with ticking (R4 R5)
    step(1'b1, 1'b1, 8'hA0, 32'h2);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'h00, 32'd0);
    // re-requests while pending and at completion edge (R7)
    step(1'b1, 1'b1, 8'hA0, 32'h2);
    step(1'b1, 1'b1, 8'hA0, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 8'hA0, 32'h2);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h00, 32'd0);
    // writes without effect (R8)
    step(1'b1, 1'b1, 8'hA0, 32'hFFFF_FFFD);
    step(1'b1, 1'b1, 8'hA4, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 8'hA8, 32'hFFFF_FFFF);
    step(1'b0, 1'b1, 8'h00, 32'h2);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h00, 32'd0);
    // snapshot with ticks stopped, then back-to-back requests (R2 R5)
    step(1'b0, 1'b1, 8'hA0, 32'h2);
    step(1'b0, 1'b0, 8'h00, 32'd0);
    step(1'b0, 1'b0, 8'h00, 32'd0);
    step(1'b1, 1'b1, 8'hA0, 32'h2);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    step(1'b1, 1'b0, 8'h00, 32'd0);
    step(1'b1, 1'b1, 8'hA0, 32'h2);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      case ($urandom_range(0, 3))
        0: a = 8'hA0; 1: a = 8'hA4; 2: a = 8'hA8; default: a = 8'h10;
      endcase
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, $urandom());
    end
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'h00, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule